// File: doc/BRIEF.md
# ADC Cross-Trigger Event Router

This block turns timer events straight into ADC conversion starts, so no interrupt handler has to sit between the timer and the converter. It watches up to 64 trigger lines. Each line has its own routing entry, which holds an enable bit and the ADC channel to convert. When an enabled line fires, the router issues a start for that channel on a small start/abort/done interface to the ADC sequencer. Sources of the periodic-timer kind get a one-cycle acknowledge back. Capture/compare sources clear their own flags and get none. A flag records that a triggered conversion has completed.

The same ADC port also carries normal (software-started) conversions. A trigger that arrives during a normal conversion behaves like an injected conversion. The normal conversion is aborted, the triggered conversion runs, and then the normal conversion is started again on the same channel. Triggers that collide, or that arrive while a triggered conversion is running, wait as pending bits. They are served lowest source index first. The converter is outside the block: it answers each start with a done pulse some cycles later.

Top module: `xtrig_router`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wen` (1 enable bit) and `cfg_wchan` (7 channel bits) in the entry chosen by the 6-bit `cfg_idx`. One cycle after `cfg_idx` is presented, `cfg_rd_en`/`cfg_rd_chan` show that entry.
- R2: Assume the router is idle, nothing is pending, and a lower index is not firing. If an enabled source pulses `trig_in`, then `adc_start` is high for exactly one cycle, one clock after the trigger edge, with `adc_chan` equal to that source's channel.
- R3: Bit i of the `TIMER_MASK` parameter marks source i as the periodic-timer type. Such a source, when enabled, receives a one-cycle `ack_out[i]` pulse one clock after its trigger. A source whose mask bit is 0 never receives an acknowledge.
- R4: A trigger from a source whose enable bit is 0 produces no `adc_start` and no acknowledge.
- R5: If an enabled trigger arrives while a normal conversion is running, `adc_start` and `adc_abort` are high together one clock later, with the triggered channel. After that conversion's `adc_done`, the normal conversion is started again on its original channel with `adc_abort` low. `norm_done` pulses only after the restarted conversion completes.
- R6: `eoc_flag` is set when a triggered conversion reports `adc_done`. It stays set until `eoc_clr` is pulsed high. If a set and a clear fall in the same cycle, the set wins.
- R7: Several enabled triggers in one cycle, or triggers during a triggered conversion, are held pending. Each time the port becomes free, the lowest pending source index starts next.
- R8: Reset clears every routing entry, every pending bit, the normal request, `eoc_flag` and all output pulses.
- R9: When the router is idle with nothing pending, a `norm_start` pulse with `norm_chan` produces `adc_start` with that channel and `adc_abort` low one clock later. On its `adc_done`, `norm_done` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a routing entry |
| cfg_idx | input | 6 | Entry index for write and readback |
| cfg_wen | input | 1 | Enable bit to write |
| cfg_wchan | input | 7 | ADC channel to write |
| cfg_rd_en | output | 1 | Readback of the enable bit |
| cfg_rd_chan | output | 7 | Readback of the channel |
| trig_in | input | 64 | Trigger event pulses, one per source |
| ack_out | output | 64 | Acknowledge pulses to timer-type sources |
| norm_start | input | 1 | Request a normal conversion |
| norm_chan | input | 7 | Channel of the normal conversion |
| norm_done | output | 1 | Normal conversion completed |
| adc_start | output | 1 | Start pulse to the ADC sequencer |
| adc_abort | output | 1 | Abort the running conversion, with a start |
| adc_chan | output | 7 | Channel for `adc_start` |
| adc_done | input | 1 | Conversion finished, from the ADC |
| eoc_clr | input | 1 | Write-1 clear of `eoc_flag` |
| eoc_flag | output | 1 | A triggered conversion has finished |

## Verification
The assertions check several rules on every cycle:
- An acknowledge only follows a trigger on the same line.
- An abort never appears without a start.
- `eoc_flag` and `norm_done` only rise after `adc_done`.
- Reset leaves the outputs quiet.

Other behaviour needs a whole sequence of events, so only the bench scenarios can show it:
- The exact one-cycle start latency and the routed channel for each of the 64 sources.
- The ascending order in which queued triggers are served.
- Restarting a preempted normal conversion on its original channel.
- Holding and clearing `eoc_flag`.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_XT   = 2'd2
  } xt_state_e;
endpackage

// File: rtl/xtrig_cfg_regs.sv
module xtrig_cfg_regs #(
  parameter int NSRC = 64,
  parameter int CHW  = 7,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic            wen,
  input  logic [CHW-1:0]  wchan,
  input  logic [IDXW-1:0] sel_idx,
  output logic [NSRC-1:0] en_vec,
  output logic [CHW-1:0]  sel_chan,
  output logic            rd_en,
  output logic [CHW-1:0]  rd_chan
);
  logic [CHW-1:0] chan_mem [NSRC];

  // Enable bits are needed in parallel, channels only by index
  always_ff @(posedge clk) begin
    if (rst) begin
      en_vec  <= '0;
      rd_en   <= 1'b0;
      rd_chan <= '0;
    end else begin
      if (we) en_vec[idx] <= wen;
      rd_en   <= en_vec[idx];
      rd_chan <= chan_mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) chan_mem[i] <= '0;
    end else if (we) begin
      chan_mem[idx] <= wchan;
    end
  end

  assign sel_chan = chan_mem[sel_idx];
endmodule

// File: rtl/xtrig_pick.sv
module xtrig_pick #(
  parameter int NSRC = 64,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  // Lowest set index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/xtrig_seq.sv
module xtrig_seq
  import xtrig_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int CHW  = 7,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hit,
  output logic [NSRC-1:0] cand,
  input  logic            pick_found,
  input  logic [IDXW-1:0] pick_idx,
  input  logic [CHW-1:0]  pick_chan,
  input  logic            norm_start,
  input  logic [CHW-1:0]  norm_chan,
  output logic            norm_done,
  output logic            adc_start,
  output logic            adc_abort,
  output logic [CHW-1:0]  adc_chan,
  input  logic            adc_done,
  input  logic            eoc_clr,
  output logic            eoc_flag
);
  xt_state_e       state;
  logic [NSRC-1:0] pend;
  logic            norm_pend;
  logic [CHW-1:0]  norm_ch;
  logic            norm_want;
  logic [CHW-1:0]  norm_sel;
  logic [NSRC-1:0] pick_mask;

  assign cand      = pend | hit;
  assign norm_want = norm_pend | norm_start;
  assign norm_sel  = norm_pend ? norm_ch : norm_chan;
  assign pick_mask = NSRC'(1) << pick_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= '0;
      norm_pend <= 1'b0;
      norm_ch   <= '0;
      norm_done <= 1'b0;
      adc_start <= 1'b0;
      adc_abort <= 1'b0;
      adc_chan  <= '0;
      eoc_flag  <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      adc_abort <= 1'b0;
      norm_done <= 1'b0;
      pend      <= cand;
      if (eoc_clr) eoc_flag <= 1'b0;
      if (norm_start && !norm_pend) begin
        norm_pend <= 1'b1;
        norm_ch   <= norm_chan;
      end
      unique case (state)
        ST_NORM: begin
          if (adc_done) begin
            norm_done <= 1'b1;
            norm_pend <= 1'b0;
            state     <= ST_IDLE;
          end else if (pick_found) begin
            adc_start <= 1'b1;
            adc_abort <= 1'b1;
            adc_chan  <= pick_chan;
            pend      <= cand & ~pick_mask;
            state     <= ST_XT;
          end
        end
        ST_XT: begin
          if (adc_done) begin
            eoc_flag <= 1'b1;
            if (pick_found) begin
              adc_start <= 1'b1;
              adc_chan  <= pick_chan;
              pend      <= cand & ~pick_mask;
              state     <= ST_XT;
            end else if (norm_want) begin
              adc_start <= 1'b1;
              adc_chan  <= norm_sel;
              norm_pend <= 1'b1;
              norm_ch   <= norm_sel;
              state     <= ST_NORM;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          if (pick_found) begin
            adc_start <= 1'b1;
            adc_chan  <= pick_chan;
            pend      <= cand & ~pick_mask;
            state     <= ST_XT;
          end else if (norm_want) begin
            adc_start <= 1'b1;
            adc_chan  <= norm_sel;
            norm_pend <= 1'b1;
            norm_ch   <= norm_sel;
            state     <= ST_NORM;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xtrig_router.sv
module xtrig_router #(
  parameter int NSRC = 64,
  parameter int CHW  = 7,
  parameter logic [NSRC-1:0] TIMER_MASK = {NSRC{1'b1}},
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic            cfg_wen,
  input  logic [CHW-1:0]  cfg_wchan,
  output logic            cfg_rd_en,
  output logic [CHW-1:0]  cfg_rd_chan,
  input  logic [NSRC-1:0] trig_in,
  output logic [NSRC-1:0] ack_out,
  input  logic            norm_start,
  input  logic [CHW-1:0]  norm_chan,
  output logic            norm_done,
  output logic            adc_start,
  output logic            adc_abort,
  output logic [CHW-1:0]  adc_chan,
  input  logic            adc_done,
  input  logic            eoc_clr,
  output logic            eoc_flag
);
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] hit;
  logic [NSRC-1:0] cand;
  logic            pick_found;
  logic [IDXW-1:0] pick_idx;
  logic [CHW-1:0]  pick_chan;

  assign hit = trig_in & en_vec;

  xtrig_cfg_regs #(.NSRC(NSRC), .CHW(CHW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wen(cfg_wen),
    .wchan(cfg_wchan), .sel_idx(pick_idx), .en_vec(en_vec),
    .sel_chan(pick_chan), .rd_en(cfg_rd_en), .rd_chan(cfg_rd_chan)
  );

  xtrig_pick #(.NSRC(NSRC)) u_pick (
    .req(cand), .found(pick_found), .idx(pick_idx)
  );

  xtrig_seq #(.NSRC(NSRC), .CHW(CHW)) u_seq (
    .clk(clk), .rst(rst), .hit(hit), .cand(cand),
    .pick_found(pick_found), .pick_idx(pick_idx), .pick_chan(pick_chan),
    .norm_start(norm_start), .norm_chan(norm_chan), .norm_done(norm_done),
    .adc_start(adc_start), .adc_abort(adc_abort), .adc_chan(adc_chan),
    .adc_done(adc_done), .eoc_clr(eoc_clr), .eoc_flag(eoc_flag)
  );

  // Acknowledge flops exist only for timer-type sources
  for (genvar g = 0; g < NSRC; g++) begin : g_ack
    if (TIMER_MASK[g]) begin : g_timer
      always_ff @(posedge clk) begin
        if (rst) ack_out[g] <= 1'b0;
        else     ack_out[g] <= hit[g];
      end
    end else begin : g_self
      assign ack_out[g] = 1'b0;
    end
  end
endmodule

// File: rtl/xtrig_router_chk.sv
module xtrig_router_chk #(
  parameter int NSRC = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] trig_in,
  input logic [NSRC-1:0] ack_out,
  input logic            adc_start,
  input logic            adc_abort,
  input logic            adc_done,
  input logic            eoc_flag,
  input logic            norm_done
);
  // R3
  ack_follows_trig_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ack_out & ~$past(trig_in)) == '0));

  // R5
  abort_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    adc_abort |-> adc_start);

  // R6
  eoc_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_flag) |-> $past(adc_done));

  // R9
  norm_done_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    norm_done |-> $past(adc_done));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!adc_start && !eoc_flag && !norm_done && ack_out == '0));
endmodule

bind xtrig_router xtrig_router_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .trig_in(trig_in), .ack_out(ack_out),
  .adc_start(adc_start), .adc_abort(adc_abort), .adc_done(adc_done),
  .eoc_flag(eoc_flag), .norm_done(norm_done)
);

// File: tb/xtrig_router_tb.sv
module xtrig_router_tb;
  localparam int NSRC = 64;
  localparam int CHW  = 7;
  localparam logic [NSRC-1:0] TMASK = 64'h0F0F_0F0F_0F0F_0F0F;
  localparam int LAT  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_idx = '0;
  logic cfg_wen = 1'b0;
  logic [CHW-1:0] cfg_wchan = '0;
  logic cfg_rd_en;
  logic [CHW-1:0] cfg_rd_chan;
  logic [NSRC-1:0] trig_in = '0;
  logic [NSRC-1:0] ack_out;
  logic norm_start = 1'b0;
  logic [CHW-1:0] norm_chan = '0;
  logic norm_done, adc_start, adc_abort, adc_done, eoc_flag;
  logic [CHW-1:0] adc_chan;
  logic eoc_clr = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  xtrig_router #(.NSRC(NSRC), .CHW(CHW), .TIMER_MASK(TMASK)) u_dut (.*);

  // ADC model: done LAT edges after the start is seen
  logic [3:0] acnt;
  always @(posedge clk) begin
    if (rst) acnt <= '0;
    else if (adc_start) acnt <= 4'(LAT);
    else if (acnt != 0) acnt <= acnt - 1'b1;
  end
  assign adc_done = (acnt == 4'd1);

  // Start log and normal-done counter
  logic [CHW-1:0] log_ch [64];
  logic log_ab [64];
  int log_n = 0;
  int nd_cnt = 0;
  always @(negedge clk) begin
    if (!rst && adc_start && log_n < 64) begin
      log_ch[log_n] = adc_chan;
      log_ab[log_n] = adc_abort;
      log_n = log_n + 1;
    end
    if (!rst && norm_done) nd_cnt = nd_cnt + 1;
  end

  function automatic logic [CHW-1:0] exp_ch(int i);
    return CHW'((i * 5 + 3) % 128);
  endfunction
  function automatic logic exp_en(int i);
    return (i % 3) != 0;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    int nd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(!adc_start && !eoc_flag && !norm_done && ack_out == '0, "R8 outputs", adc_start, 0);
    chk(!cfg_rd_en && cfg_rd_chan == 0, "R8 entry0", cfg_rd_chan, 0);

    // R1 write all entries, read each back
    for (int i = 0; i < NSRC; i++) begin
      cfg_we = 1'b1; cfg_idx = 6'(i); cfg_wen = exp_en(i); cfg_wchan = exp_ch(i);
      @(negedge clk);
    end
    cfg_we = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      cfg_idx = 6'(i);
      @(negedge clk);
      chk(cfg_rd_en == exp_en(i) && cfg_rd_chan == exp_ch(i), "R1 readback",
          {cfg_rd_en, cfg_rd_chan}, {exp_en(i), exp_ch(i)});
    end

    // R2 R3 R4 R6 sweep every source
    for (int i = 0; i < NSRC; i++) begin
      trig_in = NSRC'(1) << i;
      @(negedge clk);
      trig_in = '0;
      if (exp_en(i)) begin
        chk(adc_start && !adc_abort && adc_chan == exp_ch(i), "R2 start", adc_chan, exp_ch(i));
        chk(ack_out == (TMASK[i] ? NSRC'(1) << i : '0), "R3 ack", ack_out,
            TMASK[i] ? NSRC'(1) << i : 0);
      end else begin
        chk(!adc_start && ack_out == '0, "R4 ignored", {adc_start, ack_out}, 0);
      end
      @(negedge clk);
      chk(!adc_start && ack_out == '0, "R2 single pulse", {adc_start, ack_out}, 0);
      repeat (7) @(negedge clk);
      chk(eoc_flag == exp_en(i), "R6 flag set", eoc_flag, exp_en(i));
      repeat (2) @(negedge clk);
      chk(eoc_flag == exp_en(i), "R6 flag held", eoc_flag, exp_en(i));
      eoc_clr = 1'b1;
      @(negedge clk);
      eoc_clr = 1'b0;
      chk(!eoc_flag, "R6 flag cleared", eoc_flag, 0);
    end

    // R7 collision plus a lower trigger arriving while busy
    base = log_n;
    trig_in = (NSRC'(1) << 8) | (NSRC'(1) << 4) | (NSRC'(1) << 2);
    @(negedge clk);
    trig_in = NSRC'(1) << 1;
    @(negedge clk);
    trig_in = '0;
    repeat (30) @(negedge clk);
    chk(log_n == base + 4, "R7 count", log_n - base, 4);
    if (log_n == base + 4) begin
      chk(log_ch[base] == exp_ch(2), "R7 first", log_ch[base], exp_ch(2));
      chk(log_ch[base+1] == exp_ch(1), "R7 second", log_ch[base+1], exp_ch(1));
      chk(log_ch[base+2] == exp_ch(4), "R7 third", log_ch[base+2], exp_ch(4));
      chk(log_ch[base+3] == exp_ch(8), "R7 fourth", log_ch[base+3], exp_ch(8));
    end

    // R9 plain normal conversion
    nd0 = nd_cnt;
    norm_start = 1'b1; norm_chan = 7'd5;
    @(negedge clk);
    norm_start = 1'b0;
    chk(adc_start && !adc_abort && adc_chan == 7'd5, "R9 start", adc_chan, 5);
    repeat (10) @(negedge clk);
    chk(nd_cnt == nd0 + 1, "R9 done", nd_cnt - nd0, 1);

    // R5 preemption and resume
    base = log_n;
    nd0 = nd_cnt;
    norm_start = 1'b1; norm_chan = 7'd77;
    @(negedge clk);
    norm_start = 1'b0;
    chk(adc_start && !adc_abort && adc_chan == 7'd77, "R9 normal start", adc_chan, 77);
    trig_in = NSRC'(1) << 2;
    @(negedge clk);
    trig_in = '0;
    chk(adc_start && adc_abort && adc_chan == exp_ch(2), "R5 abort start",
        {adc_abort, adc_chan}, {1'b1, exp_ch(2)});
    chk(nd_cnt == nd0, "R5 no early done", nd_cnt - nd0, 0);
    repeat (20) @(negedge clk);
    chk(log_n == base + 3 && log_ch[base+2] == 7'd77 && !log_ab[base+2], "R5 resume",
        log_ch[base+2], 77);
    chk(nd_cnt == nd0 + 1, "R5 done once", nd_cnt - nd0, 1);

    // R8 reset mid-run clears configuration
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cfg_idx = 6'd4;
    @(negedge clk);
    chk(!cfg_rd_en && cfg_rd_chan == 0, "R8 entry cleared", cfg_rd_chan, 0);
    trig_in = NSRC'(1) << 4;
    @(negedge clk);
    trig_in = '0;
    chk(!adc_start && ack_out == '0, "R8 disabled after reset", adc_start, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule